// File: doc/BRIEF.md
# Multi-Seed Integer Motion Step Search Controller

This block steers the integer-pel motion search of one macroblock. It does not compute matching costs itself. It issues candidate motion vectors one at a time over a request/response handshake to an external cost engine, and it decides from the returned costs where to look next. A search is started with one pulse. The start pulse comes with the motion vectors of the left, upper and upper-right neighbours and four extra seed vectors. When the search ends, the block emits a one-cycle completion pulse together with the winning vector and its cost.

Six starting points are refined in a fixed order: the zero vector, the component-wise median of the three neighbour vectors, and then the four extra seeds. The size of the search window depends on how strongly the neighbours move. Every starting point is clamped into that window. From each starting point the block runs a small-diamond-free, eight-neighbour step search. The centre moves to the cheapest neighbour until the centre itself is the cheapest, or until the step budget runs out.

Top module: `mvsearch_ctrl`

## Requirements
- R1: After reset, and whenever no search is running, `busy`, `done` and `req_valid` are all low.
- R2: The first request of each seed is issued in this order: the seeds are (0,0), then the neighbour median, then extra seed slot 0 to slot 3. Slot i is held in bits [i*8 +: 8] of `extra_x` and `extra_y`.
- R3: The median seed takes each component separately as the middle value of the left, up and up-right neighbour components.
- R4: The activity measure is the largest absolute value among the six neighbour components. The window half-range is 4 when the activity is below 4, and 16 otherwise. Each seed component is clamped to the range [-half, +half].
- R5: No requested vector has a component whose magnitude exceeds the current half-range.
- R6: The first step of a seed requests its centre. Each step then visits the neighbours at offset (dx,dy) in this order: (-1,-1), (0,-1), (1,-1), (-1,0), (1,0), (-1,1), (0,1), (1,1). A neighbour outside the window is skipped and is not requested. The centre is not requested again in later steps.
- R7: A step ends the seed when no neighbour costs strictly less than the centre. Otherwise the centre moves to the cheapest neighbour, and on equal costs the one visited earlier wins.
- R8: Each seed is refined for at most 8 steps. After the eighth step the seed ends at that step's best point.
- R9: `done` is high for exactly one cycle after all six seeds finish. During that cycle, `best_x`/`best_y`/`best_cost` give the lowest cost returned during the search, and among equal costs the earliest returned.
- R10: Request fields hold steady while `req_valid` is high and `req_ready` is low. After a request is accepted, no new request appears until `rsp_valid` returns the cost.
- R11: A `start` pulse while `busy` is high has no effect on the running search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search; samples all vector inputs |
| nb_left_x | input | 8 | Left neighbour MV, horizontal (signed) |
| nb_left_y | input | 8 | Left neighbour MV, vertical (signed) |
| nb_up_x | input | 8 | Upper neighbour MV, horizontal |
| nb_up_y | input | 8 | Upper neighbour MV, vertical |
| nb_upr_x | input | 8 | Upper-right neighbour MV, horizontal |
| nb_upr_y | input | 8 | Upper-right neighbour MV, vertical |
| extra_x | input | 32 | Four extra seed horizontal components, slot i at [i*8 +: 8] |
| extra_y | input | 32 | Four extra seed vertical components, slot i at [i*8 +: 8] |
| req_valid | output | 1 | Cost request pending |
| req_ready | input | 1 | Cost engine accepts the request |
| req_x | output | 8 | Requested vector, horizontal |
| req_y | output | 8 | Requested vector, vertical |
| rsp_valid | input | 1 | Cost for the accepted request is present |
| rsp_cost | input | 16 | Returned matching cost |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| best_x | output | 8 | Winning vector, horizontal |
| best_y | output | 8 | Winning vector, vertical |
| best_cost | output | 16 | Cost of the winning vector |

## Verification
The bound checker watches the handshake on every cycle. It checks that a request is held under back-pressure, that only one request is in flight, that each requested vector lies inside the active window, and that the window value stays fixed for the whole search even when `start` toggles. It also checks that the completion pulse lasts one cycle and that the interface stays quiet when idle. Only the bench scenarios can show that the search path is correct: the exact order of requested points, the median and clamp arithmetic, tie resolution, the eight-step cap, and the reported winner. The bench replays each search against its own cost landscape and compares every requested vector and the final result.

// File: rtl/mvs_pkg.sv
package mvs_pkg;
  localparam int MV_W   = 8;
  localparam int COST_W = 16;

  typedef logic signed [MV_W-1:0] mv_t;
  typedef logic [MV_W:0]          mag_t;
  typedef logic [COST_W-1:0]      cost_t;
  typedef struct packed {
    mv_t x;
    mv_t y;
  } mvec_t;

  // middle value of three signed components
  function automatic mv_t med3(mv_t a, mv_t b, mv_t c);
    mv_t lo, hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    if (c < lo)      return lo;
    else if (c > hi) return hi;
    else             return c;
  endfunction

  // magnitude, one bit wider so the most negative value fits
  function automatic mag_t mag(mv_t v);
    logic signed [MV_W:0] w;
    w = {v[MV_W-1], v};
    return v[MV_W-1] ? mag_t'(-w) : mag_t'(w);
  endfunction

  function automatic mv_t clamp_mv(mv_t v, mag_t h);
    logic signed [MV_W:0] w, hs;
    w  = {v[MV_W-1], v};
    hs = signed'(h);
    if (w > hs)       w = hs;
    else if (w < -hs) w = -hs;
    return w[MV_W-1:0];
  endfunction

  // neighbour visiting order, index 1..8 row by row skipping the centre
  function automatic logic signed [1:0] off_x(logic [3:0] k);
    case (k)
      4'd1, 4'd4, 4'd6: return -2'sd1;
      4'd3, 4'd5, 4'd8: return 2'sd1;
      default:          return 2'sd0;
    endcase
  endfunction

  function automatic logic signed [1:0] off_y(logic [3:0] k);
    case (k)
      4'd1, 4'd2, 4'd3: return -2'sd1;
      4'd6, 4'd7, 4'd8: return 2'sd1;
      default:          return 2'sd0;
    endcase
  endfunction

  function automatic logic inside_win(logic signed [MV_W:0] p, mag_t h);
    logic signed [MV_W:0] hs;
    hs = signed'(h);
    return (p <= hs) && (p >= -hs);
  endfunction
endpackage

// File: rtl/mvs_seed_gen.sv
module mvs_seed_gen
  import mvs_pkg::*;
#(
  parameter int N_EXTRA  = 4,
  parameter int HR_SMALL = 4,
  parameter int HR_LARGE = 16,
  parameter int ACT_THR  = 4,
  parameter int SEED_W   = 3
) (
  input  mvec_t                  nb_l,
  input  mvec_t                  nb_u,
  input  mvec_t                  nb_ur,
  input  mvec_t [N_EXTRA-1:0]    extra,
  input  logic  [SEED_W-1:0]     seed_idx,
  output mag_t                   hr,
  output mvec_t                  med,
  output mvec_t                  seed
);
  localparam int NSEED = 2 + N_EXTRA;

  mag_t  comp_mag [6];
  mag_t  activity;
  mvec_t raw [NSEED];
  mvec_t clp [NSEED];

  assign comp_mag[0] = mag(nb_l.x);
  assign comp_mag[1] = mag(nb_l.y);
  assign comp_mag[2] = mag(nb_u.x);
  assign comp_mag[3] = mag(nb_u.y);
  assign comp_mag[4] = mag(nb_ur.x);
  assign comp_mag[5] = mag(nb_ur.y);

  always_comb begin
    activity = '0;
    for (int i = 0; i < 6; i++)
      if (comp_mag[i] > activity) activity = comp_mag[i];
  end

  assign hr = (activity < mag_t'(ACT_THR)) ? mag_t'(HR_SMALL) : mag_t'(HR_LARGE);

  assign med.x = med3(nb_l.x, nb_u.x, nb_ur.x);
  assign med.y = med3(nb_l.y, nb_u.y, nb_ur.y);

  assign raw[0] = '0;
  assign raw[1] = med;

  genvar g;
  generate
    for (g = 0; g < N_EXTRA; g++) begin : g_extra
      assign raw[2+g] = extra[g];
    end
    for (g = 0; g < NSEED; g++) begin : g_clamp
      assign clp[g].x = clamp_mv(raw[g].x, hr);
      assign clp[g].y = clamp_mv(raw[g].y, hr);
    end
  endgenerate

  always_comb begin
    seed = '0;
    for (int i = 0; i < NSEED; i++)
      if (seed_idx == SEED_W'(i)) seed = clp[i];
  end
endmodule

// File: rtl/mvs_point_gen.sv
module mvs_point_gen
  import mvs_pkg::*;
(
  input  mvec_t       centre,
  input  logic [3:0]  pidx,
  input  mag_t        hr,
  output mvec_t       pt,
  output logic        in_win
);
  logic signed [MV_W:0] px, py;

  assign px = {centre.x[MV_W-1], centre.x} + (MV_W+1)'(off_x(pidx));
  assign py = {centre.y[MV_W-1], centre.y} + (MV_W+1)'(off_y(pidx));

  assign pt.x   = px[MV_W-1:0];
  assign pt.y   = py[MV_W-1:0];
  assign in_win = inside_win(px, hr) && inside_win(py, hr);
endmodule

// File: rtl/mvs_best_trk.sv
module mvs_best_trk
  import mvs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ev_centre,
  input  logic  ev_nb,
  input  logic  ev_seed,
  input  logic  first_seed,
  input  mvec_t pt,
  input  cost_t cost,
  output mvec_t lb,
  output cost_t lb_cost,
  output mvec_t gb,
  output cost_t gb_cost,
  output logic  nb_better,
  output logic  seed_better
);
  assign nb_better   = cost < lb_cost;
  assign seed_better = first_seed || (lb_cost < gb_cost);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lb      <= '0;
      lb_cost <= '0;
      gb      <= '0;
      gb_cost <= '0;
    end else begin
      if (ev_centre) begin
        lb      <= pt;
        lb_cost <= cost;
      end else if (ev_nb && nb_better) begin
        lb      <= pt;
        lb_cost <= cost;
      end
      if (ev_seed && seed_better) begin
        gb      <= lb;
        gb_cost <= lb_cost;
      end
    end
  end
endmodule

// File: rtl/mvsearch_ctrl.sv
module mvsearch_ctrl
  import mvs_pkg::*;
#(
  parameter int N_EXTRA  = 4,
  parameter int HR_SMALL = 4,
  parameter int HR_LARGE = 16,
  parameter int ACT_THR  = 4,
  parameter int MAX_ITER = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic signed [MV_W-1:0]    nb_left_x,
  input  logic signed [MV_W-1:0]    nb_left_y,
  input  logic signed [MV_W-1:0]    nb_up_x,
  input  logic signed [MV_W-1:0]    nb_up_y,
  input  logic signed [MV_W-1:0]    nb_upr_x,
  input  logic signed [MV_W-1:0]    nb_upr_y,
  input  logic [N_EXTRA*MV_W-1:0]   extra_x,
  input  logic [N_EXTRA*MV_W-1:0]   extra_y,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic signed [MV_W-1:0]    req_x,
  output logic signed [MV_W-1:0]    req_y,
  input  logic                      rsp_valid,
  input  logic [COST_W-1:0]         rsp_cost,
  output logic                      busy,
  output logic                      done,
  output logic signed [MV_W-1:0]    best_x,
  output logic signed [MV_W-1:0]    best_y,
  output logic [COST_W-1:0]         best_cost
);
  localparam int NSEED  = 2 + N_EXTRA;
  localparam int SEED_W = $clog2(NSEED);
  localparam int ITER_W = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1;
  localparam logic [3:0] LAST_PT = 4'd9;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_REQ, S_WAIT, S_NEXT, S_STEP, S_SEED, S_DONE
  } state_t;

  state_t                  state;
  mvec_t                   lat_l, lat_u, lat_ur;
  logic [N_EXTRA*MV_W-1:0] lat_ex_x, lat_ex_y;
  mvec_t [N_EXTRA-1:0]     ex_vec;
  logic [SEED_W-1:0]       seed_idx;
  logic [ITER_W-1:0]       iter;
  logic [3:0]              pidx;
  mvec_t                   centre;

  // named internal events
  mag_t  hr;
  mvec_t med, seed_now, pt, lb, gb;
  cost_t lb_cost, gb_cost;
  logic  in_win, nb_better, seed_better;
  logic  ev_centre, ev_nb, ev_seed, moved, last_step, last_seed;

  genvar g;
  generate
    for (g = 0; g < N_EXTRA; g++) begin : g_unpack
      assign ex_vec[g].x = lat_ex_x[g*MV_W +: MV_W];
      assign ex_vec[g].y = lat_ex_y[g*MV_W +: MV_W];
    end
  endgenerate

  mvs_seed_gen #(
    .N_EXTRA(N_EXTRA), .HR_SMALL(HR_SMALL), .HR_LARGE(HR_LARGE),
    .ACT_THR(ACT_THR), .SEED_W(SEED_W)
  ) u_seed (
    .nb_l(lat_l), .nb_u(lat_u), .nb_ur(lat_ur), .extra(ex_vec),
    .seed_idx(seed_idx), .hr(hr), .med(med), .seed(seed_now)
  );

  mvs_point_gen u_point (
    .centre(centre), .pidx(pidx), .hr(hr), .pt(pt), .in_win(in_win)
  );

  assign ev_centre = (state == S_WAIT) && rsp_valid && (pidx == 4'd0);
  assign ev_nb     = (state == S_WAIT) && rsp_valid && (pidx != 4'd0);
  assign ev_seed   = (state == S_SEED);
  assign moved     = (lb != centre);
  assign last_step = (iter == ITER_W'(MAX_ITER-1));
  assign last_seed = (seed_idx == SEED_W'(NSEED-1));

  mvs_best_trk u_best (
    .clk(clk), .rst_n(rst_n), .ev_centre(ev_centre), .ev_nb(ev_nb),
    .ev_seed(ev_seed), .first_seed(seed_idx == '0), .pt(pt), .cost(rsp_cost),
    .lb(lb), .lb_cost(lb_cost), .gb(gb), .gb_cost(gb_cost),
    .nb_better(nb_better), .seed_better(seed_better)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      lat_l    <= '0;
      lat_u    <= '0;
      lat_ur   <= '0;
      lat_ex_x <= '0;
      lat_ex_y <= '0;
      seed_idx <= '0;
      iter     <= '0;
      pidx     <= '0;
      centre   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          lat_l    <= '{x: nb_left_x, y: nb_left_y};
          lat_u    <= '{x: nb_up_x,   y: nb_up_y};
          lat_ur   <= '{x: nb_upr_x,  y: nb_upr_y};
          lat_ex_x <= extra_x;
          lat_ex_y <= extra_y;
          seed_idx <= '0;
          state    <= S_LOAD;
        end
        S_LOAD: begin
          centre <= seed_now;
          pidx   <= 4'd0;
          iter   <= '0;
          state  <= S_REQ;
        end
        S_REQ:  if (req_ready) state <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          pidx  <= pidx + 4'd1;
          state <= S_NEXT;
        end
        S_NEXT: begin
          if (pidx == LAST_PT)  state <= S_STEP;
          else if (in_win)      state <= S_REQ;
          else                  pidx  <= pidx + 4'd1;
        end
        S_STEP: begin
          if (!moved || last_step) state <= S_SEED;
          else begin
            centre <= lb;
            iter   <= iter + 1'b1;
            pidx   <= 4'd1;
            state  <= S_NEXT;
          end
        end
        S_SEED: begin
          if (last_seed) state <= S_DONE;
          else begin
            seed_idx <= seed_idx + 1'b1;
            state    <= S_LOAD;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_valid = (state == S_REQ);
  assign req_x     = pt.x;
  assign req_y     = pt.y;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign best_x    = gb.x;
  assign best_y    = gb.y;
  assign best_cost = gb_cost;
endmodule

// File: rtl/mvs_ctrl_chk.sv
module mvs_ctrl_chk
  import mvs_pkg::*;
#(
  parameter int HR_SMALL = 4,
  parameter int HR_LARGE = 16
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input mv_t  req_x,
  input mv_t  req_y,
  input mag_t hr
);
  logic in_flight;

  always_ff @(posedge clk) begin
    if (!rst_n)                       in_flight <= 1'b0;
    else if (req_valid && req_ready)  in_flight <= 1'b1;
    else if (rsp_valid)               in_flight <= 1'b0;
  end

  // R1: quiet request side while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !done);

  // R4: window is one of the two sizes during a search
  a_r4_hr_choice: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (hr == mag_t'(HR_SMALL)) || (hr == mag_t'(HR_LARGE)));

  // R5: every requested point lies inside the window
  a_r5_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (mag(req_x) <= hr) && (mag(req_y) <= hr));

  // R10: request held under back-pressure
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_x) && $stable(req_y));

  // R10: single outstanding request
  a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |-> !req_valid);

  // R9: completion is a single-cycle pulse
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: window stays fixed through the search regardless of start
  a_r11_window_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(done) |-> $stable(hr));

  // start is observed only to document that it may toggle mid-search
  a_r11_start_known: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |-> !$isunknown(hr));
endmodule

bind mvsearch_ctrl mvs_ctrl_chk #(.HR_SMALL(HR_SMALL), .HR_LARGE(HR_LARGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .req_x(req_x), .req_y(req_y), .hr(hr)
);

// File: tb/tb_mvsearch_ctrl.sv
module tb_mvsearch_ctrl;
  localparam int MVW = mvs_pkg::MV_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [MVW-1:0] nbl_x, nbl_y, nbu_x, nbu_y, nbr_x, nbr_y;
  logic [4*MVW-1:0] ex_x_bus, ex_y_bus;
  logic req_valid, req_ready;
  logic signed [MVW-1:0] req_x, req_y;
  logic rsp_valid;
  logic [15:0] rsp_cost;
  logic busy, done;
  logic signed [MVW-1:0] best_x, best_y;
  logic [15:0] best_cost;

  always #2 clk = ~clk;  // 250 MHz

  mvsearch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .nb_left_x(nbl_x), .nb_left_y(nbl_y), .nb_up_x(nbu_x), .nb_up_y(nbu_y),
    .nb_upr_x(nbr_x), .nb_upr_y(nbr_y), .extra_x(ex_x_bus), .extra_y(ex_y_bus),
    .req_valid(req_valid), .req_ready(req_ready), .req_x(req_x), .req_y(req_y),
    .rsp_valid(rsp_valid), .rsp_cost(rsp_cost), .busy(busy), .done(done),
    .best_x(best_x), .best_y(best_y), .best_cost(best_cost)
  );

  int errors = 0;
  int checks = 0;

  // scenario
  int nb[6];       // lx, ly, ux, uy, rx, ry
  int ex[8];       // x0, y0, x1, y1, ...
  int tx, ty;
  bit flat, poke;

  // expected trajectory
  int exp_x[512], exp_y[512];
  int n_exp, exp_bx, exp_by, exp_bc, hwin, seed1_at;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int absi(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int middle(int a, int b, int c);
    int t[3];
    int s;
    t[0] = a; t[1] = b; t[2] = c;
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2 - i; j++)
        if (t[j] > t[j+1]) begin s = t[j]; t[j] = t[j+1]; t[j+1] = s; end
    return t[1];
  endfunction

  function automatic int lim(int v, int h);
    if (v > h) return h;
    if (v < -h) return -h;
    return v;
  endfunction

  function automatic int cost_of(int x, int y);
    if (flat) return 100;
    return (absi(x - tx) + absi(y - ty)) * 8 + ((x * 5 + y * 3) & 7);
  endfunction

  task automatic push(input int x, input int y);
    int c;
    exp_x[n_exp] = x;
    exp_y[n_exp] = y;
    n_exp++;
    c = cost_of(x, y);
    if (c < exp_bc) begin exp_bc = c; exp_bx = x; exp_by = y; end
  endtask

  // R4 R6 R7 R8 R9 behaviour restated as a sequential walk
  task automatic build_model();
    int act, cx, cy, cc, bx, by, bc, px, py, k;
    int sx[6], sy[6];
    act = 0;
    for (int i = 0; i < 6; i++) if (absi(nb[i]) > act) act = absi(nb[i]);
    hwin = (act < 4) ? 4 : 16;
    sx[0] = 0; sy[0] = 0;
    sx[1] = middle(nb[0], nb[2], nb[4]);
    sy[1] = middle(nb[1], nb[3], nb[5]);
    for (int i = 0; i < 4; i++) begin sx[2+i] = ex[2*i]; sy[2+i] = ex[2*i+1]; end
    n_exp = 0; exp_bc = 1 << 30; exp_bx = 0; exp_by = 0; seed1_at = 0;
    for (int s = 0; s < 6; s++) begin
      cx = lim(sx[s], hwin); cy = lim(sy[s], hwin);
      if (s == 1) seed1_at = n_exp;
      push(cx, cy);
      cc = cost_of(cx, cy);
      for (int it = 0; it < 8; it++) begin
        bx = cx; by = cy; bc = cc;
        for (int n = 0; n < 8; n++) begin
          k = (n < 4) ? n : n + 1;
          px = cx + (k % 3) - 1;
          py = cy + (k / 3) - 1;
          if (absi(px) <= hwin && absi(py) <= hwin) begin
            push(px, py);
            if (cost_of(px, py) < bc) begin bc = cost_of(px, py); bx = px; by = py; end
          end
        end
        if (bx == cx && by == cy) break;
        cx = bx; cy = by; cc = bc;
      end
    end
  endtask

  task automatic run_mb(input string name);
    int k, guard, first_bad_k, ax, ay, stall, lat;
    bit seq_ok, win_ok, seen_done;
    build_model();
    nbl_x = MVW'(nb[0]); nbl_y = MVW'(nb[1]);
    nbu_x = MVW'(nb[2]); nbu_y = MVW'(nb[3]);
    nbr_x = MVW'(nb[4]); nbr_y = MVW'(nb[5]);
    for (int i = 0; i < 4; i++) begin
      ex_x_bus[i*MVW +: MVW] = MVW'(ex[2*i]);
      ex_y_bus[i*MVW +: MVW] = MVW'(ex[2*i+1]);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0; guard = 0; seq_ok = 1; win_ok = 1; seen_done = 0; first_bad_k = -1;
    ax = 0; ay = 0;
    while (!seen_done && guard < 30000) begin
      if (done) begin
        seen_done = 1;
        check(best_x == MVW'(exp_bx), {name, " R9 best_x"}, int'(best_x), exp_bx);
        check(best_y == MVW'(exp_by), {name, " R9 best_y"}, int'(best_y), exp_by);
        check(int'(best_cost) == exp_bc, {name, " R9 best_cost"}, int'(best_cost), exp_bc);
        @(negedge clk);
        check(!done, {name, " R9 pulse width"}, int'(done), 0);
      end else if (req_valid) begin
        ax = int'(req_x); ay = int'(req_y);
        if (absi(ax) > hwin || absi(ay) > hwin) win_ok = 0;
        if (seq_ok && (k >= n_exp || ax != exp_x[k] || ay != exp_y[k])) begin
          seq_ok = 0; first_bad_k = k;
        end
        if (k == seed1_at)  // R2 R3: median seed opens the second seed
          check(ax == lim(middle(nb[0], nb[2], nb[4]), hwin) &&
                ay == lim(middle(nb[1], nb[3], nb[5]), hwin),
                {name, " R3 median seed"}, ax * 1000 + ay,
                lim(middle(nb[0], nb[2], nb[4]), hwin) * 1000 + lim(middle(nb[1], nb[3], nb[5]), hwin));
        k++;
        stall = $urandom_range(0, 2);
        repeat (stall) @(negedge clk);
        req_ready = 1'b1;
        if (poke && k == 3) begin  // R11: start while busy with altered inputs
          start = 1'b1;
          nbl_x = 8'sd60; ex_x_bus = '1;
        end
        @(negedge clk);
        req_ready = 1'b0;
        start = 1'b0;
        lat = $urandom_range(0, 2);
        repeat (lat) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_cost = 16'(cost_of(ax, ay));
        @(negedge clk);
        rsp_valid = 1'b0;
        guard = guard + 4;
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    check(seen_done, {name, " R9 completion seen"}, int'(seen_done), 1);
    if (!seq_ok)
      $display("  %s first diverging request index %0d", name, first_bad_k);
    check(seq_ok, {name, " R6 R7 R8 request sequence"}, first_bad_k, -1);
    check(k == n_exp, {name, " R10 request count"}, k, n_exp);
    check(win_ok, {name, " R5 window"}, int'(win_ok), 1);
    @(negedge clk);
    check(!busy && !req_valid, {name, " R1 idle after done"}, int'(busy), 0);
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < 6; i++) nb[i] = 0;
    for (int i = 0; i < 8; i++) ex[i] = 0;
    tx = 0; ty = 0; flat = 0; poke = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(1234);
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_cost = '0;
    nbl_x = '0; nbl_y = '0; nbu_x = '0; nbu_y = '0; nbr_x = '0; nbr_y = '0;
    ex_x_bus = '0; ex_y_bus = '0;
    repeat (4) @(negedge clk);
    check(!busy && !done && !req_valid, "R1 reset state", int'(busy) + int'(done) + int'(req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 small window, target outside it: walk to the edge
    clear_cfg(); tx = 20; ty = -12; nb[0] = 3; nb[3] = -2;
    ex[0] = 30; ex[1] = -30; ex[6] = -5;
    run_mb("low_act");

    // R4 activity exactly at threshold gives the large window
    clear_cfg(); tx = 9; ty = 9; nb[4] = -4; ex[2] = 100; ex[3] = -100;
    run_mb("thr_act");

    // R7 flat cost: every seed stops after one step, first point wins
    clear_cfg(); flat = 1; nb[0] = 7; nb[1] = -9; nb[2] = 2; nb[5] = 11;
    ex[0] = 3; ex[1] = 3;
    run_mb("flat");

    // R8 far diagonal target from the zero seed hits the step cap
    clear_cfg(); tx = 15; ty = 15; nb[1] = 20;
    run_mb("cap");

    // R3 median with mixed signs; R11 start pulse mid-search
    clear_cfg(); tx = -6; ty = 4; poke = 1;
    nb[0] = -10; nb[2] = 5; nb[4] = -2; nb[1] = 8; nb[3] = -7; nb[5] = 1;
    ex[4] = -16; ex[5] = 16;
    run_mb("median_poke");

    for (int r = 0; r < 24; r++) begin
      clear_cfg();
      for (int i = 0; i < 6; i++)
        nb[i] = ($urandom_range(0, 1) == 0) ? int'($urandom_range(0, 6)) - 3
                                             : int'($urandom_range(0, 40)) - 20;
      for (int i = 0; i < 8; i++) ex[i] = int'($urandom_range(0, 80)) - 40;
      tx = int'($urandom_range(0, 40)) - 20;
      ty = int'($urandom_range(0, 40)) - 20;
      poke = ($urandom_range(0, 3) == 0);
      run_mb($sformatf("rand%0d", r));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule